// File: doc/BRIEF.md
# ATA Task-File Device Register Model

This block is the device side of an ATA command block, as seen from a host register bus. It stores the task-file registers and answers status polls. It decodes two commands: IDENTIFY, which returns a 256-word information block through the 16-bit data port, and the 48-bit READ DMA EXT command, which raises a DMA request toward a bus-master engine. It runs BSY, DRQ and ERR through a small sequencer. It does not model media access or cable timing. During a DMA transfer it presents the block address of the sector currently moving on `cur_lba`, so that a media model outside the block can supply the data.

The count register and the three address registers each keep two bytes: the byte most recently written and the byte written before it. To program a 48-bit address, the host writes each of these registers twice, high-order byte first. One 8-bit port therefore supplies both halves of a 48-bit address and of a 16-bit sector count. The drive/head register selects between a master and an optional slave. An absent drive reads as status 0.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status (command-block offset 7) reads 0x40, `intrq` and `dma_req` are 0, and `cur_lba` is 0.
- R2: When READ DMA EXT (0x25) is accepted, `cur_lba` loads the value {prev@5, prev@4, prev@3, last@5, last@4, last@3}, most significant byte first. Here "last" is the byte most recently written to that offset and "prev" is the byte written before it.
- R3: Reads of offsets 2 to 5 return the most recently written byte in bits 7:0, with bits 15:8 at 0. Offset 6 returns the drive/head byte.
- R4: An accepted command reads as status 0x80 (BSY=bit 7) for exactly BUSY_CYCLES cycles after its write edge. No status value ever shows BSY and DRQ (bit 3) together.
- R5: IDENTIFY (0xEC) ends its busy phase with status 0x48 and `intrq` set. Data-port reads (offset 0) then return word k = {k[7:0], ~k[7:0]}, except word 49 = 0x0100 and word 83 = 0x0400. After IDENTIFY_WORDS reads, status returns to 0x40.
- R6: READ DMA EXT ends its busy phase with `dma_req` held high and status 0x80. Each cycle in which `dma_ack` is high moves one word. `cur_lba` advances by one after each WORDS_PER_SECTOR words. After count × WORDS_PER_SECTOR words, `dma_req` drops, `intrq` is set and status reads 0x40.
- R7: The sector count is {prev@2, last@2}. A value of 0 means 65536 sectors.
- R8: An unrecognised command code sets ERR (status 0x41) in the next cycle, with no BSY phase. It sets `intrq`, and the error register (offset 1) reads 0x0004. The next accepted valid command clears ERR.
- R9: Alternate status (control-block offset 2) returns the same value as status and leaves `intrq` unchanged. A status read at offset 7 clears `intrq`, unless a completion sets it in the same cycle.
- R10: Drive/head bit 4 selects the slave. If the selected drive is absent (SLAVE_PRESENT=0), status and alternate status read 0 and command writes are ignored.
- R11: A command write is ignored while a command is busy, in its data phase or transferring by DMA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_cs | input | 1 | Command-block select |
| ctl_cs | input | 1 | Control-block select |
| reg_addr | input | 3 | Register offset within the selected block |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| reg_wdata | input | 16 | Write data (task-file registers use bits 7:0) |
| reg_rdata | output | 16 | Read data, combinational from address and strobe |
| intrq | output | 1 | Device interrupt request |
| dma_req | output | 1 | DMA request to the bus-master engine |
| dma_ack | input | 1 | One word moved in this cycle |
| cur_lba | output | 48 | Block address of the sector in transfer |

## Verification
The checker assumes a single bus access per cycle: `cmd_cs` and `ctl_cs` are never both active, and read and write never occur together. It also assumes that `dma_ack` is raised only while `dma_req` is high. The bench drives one access per cycle from a sequential stimulus process. Before it raises the acknowledge, it samples `dma_req` at the falling edge. The register history and the command acceptance depend on an ordered write stream, so the bench never mixes a task-file write with a command write in the same cycle.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_PIO  = 2'd2,
        ST_DMA  = 2'd3
    } tf_state_e;

    localparam int HIST_REGS = 4;          // count, addr lo, addr mid, addr hi

    localparam logic [2:0] OFS_DATA    = 3'd0;
    localparam logic [2:0] OFS_ERR     = 3'd1;
    localparam logic [2:0] OFS_COUNT   = 3'd2;
    localparam logic [2:0] OFS_ADDR_HI = 3'd5;
    localparam logic [2:0] OFS_SELECT  = 3'd6;
    localparam logic [2:0] OFS_CMDSTAT = 3'd7;
    localparam logic [2:0] OFS_ALTSTAT = 3'd2;

    localparam logic [7:0] OP_IDENTIFY  = 8'hEC;
    localparam logic [7:0] OP_RD_DMA48  = 8'h25;

    localparam int SEL_DEV_BIT = 4;

endpackage

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile
    import ata_tf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                addr,
    input  logic [7:0]                wdata,
    output logic [HIST_REGS-1:0][7:0] last_bytes,
    output logic [7:0]                sel_byte,
    output logic [47:0]               lba_value,
    output logic [16:0]               sect_value
);

    typedef struct packed {
        logic [HIST_REGS-1:0][7:0] last;
        logic [HIST_REGS-1:0][7:0] prev;
        logic [7:0]                sel;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [HIST_REGS-1:0] hit;

    for (genvar g = 0; g < HIST_REGS; g++) begin : g_hit
        assign hit[g] = wr_en && (addr == 3'(int'(OFS_COUNT) + g));
    end

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < HIST_REGS; i++) begin
            if (hit[i]) begin
                rf_d.prev[i] = rf_q.last[i];
                rf_d.last[i] = wdata;
            end
        end
        if (wr_en && addr == OFS_SELECT) begin
            rf_d.sel = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign last_bytes = rf_q.last;
    assign sel_byte   = rf_q.sel;
    assign lba_value  = {rf_q.prev[3], rf_q.prev[2], rf_q.prev[1],
                         rf_q.last[3], rf_q.last[2], rf_q.last[1]};
    assign sect_value = ({rf_q.prev[0], rf_q.last[0]} == 16'd0) ? 17'h10000
                      : {1'b0, rf_q.prev[0], rf_q.last[0]};

endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);

    localparam logic [15:0] WORD_DMA_CAP   = 16'h0100;
    localparam logic [15:0] WORD_LBA48_CAP = 16'h0400;

    logic [15:0] idx16;

    always_comb begin
        idx16 = 16'(idx);
        if (idx16 == 16'd49) begin
            word = WORD_DMA_CAP;
        end else if (idx16 == 16'd83) begin
            word = WORD_LBA48_CAP;
        end else begin
            word = {idx16[7:0], ~idx16[7:0]};
        end
    end

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
    import ata_tf_pkg::*;
#(
    parameter  int BUSY_CYCLES      = 4,
    parameter  int IDENTIFY_WORDS   = 256,
    parameter  int WORDS_PER_SECTOR = 256,
    localparam int MAXW   = (IDENTIFY_WORDS > WORDS_PER_SECTOR) ? IDENTIFY_WORDS : WORDS_PER_SECTOR,
    localparam int WIDX_W = (MAXW > 2) ? $clog2(MAXW) : 1,
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_code,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  logic              dma_ack,
    input  logic [47:0]       start_lba,
    input  logic [16:0]       sectors,
    output logic              bsy,
    output logic              drq,
    output logic              err,
    output logic              irq,
    output logic              dma_req,
    output logic [47:0]       lba,
    output logic [WIDX_W-1:0] word_idx
);

    typedef struct packed {
        tf_state_e         st;
        logic              job_dma;
        logic [CNT_W-1:0]  cnt;
        logic [WIDX_W-1:0] widx;
        logic [16:0]       left;
        logic              err;
        logic              irq;
        logic [47:0]       lba;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (stat_rd) begin
            c_d.irq = 1'b0;
        end
        unique case (c_q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    if (cmd_code == OP_IDENTIFY || cmd_code == OP_RD_DMA48) begin
                        c_d.st      = ST_BUSY;
                        c_d.job_dma = (cmd_code == OP_RD_DMA48);
                        c_d.cnt     = CNT_W'(BUSY_CYCLES - 1);
                        c_d.err     = 1'b0;
                        if (cmd_code == OP_RD_DMA48) begin
                            c_d.lba  = start_lba;
                            c_d.left = sectors;
                        end
                    end else begin
                        c_d.err = 1'b1;
                        c_d.irq = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (c_q.cnt == '0) begin
                    c_d.widx = '0;
                    if (c_q.job_dma) begin
                        c_d.st = ST_DMA;
                    end else begin
                        c_d.st  = ST_PIO;
                        c_d.irq = 1'b1;
                    end
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_PIO: begin
                if (data_rd) begin
                    if (c_q.widx == WIDX_W'(IDENTIFY_WORDS - 1)) begin
                        c_d.st = ST_IDLE;
                    end else begin
                        c_d.widx = c_q.widx + 1'b1;
                    end
                end
            end
            ST_DMA: begin
                if (dma_ack) begin
                    if (c_q.widx == WIDX_W'(WORDS_PER_SECTOR - 1)) begin
                        c_d.widx = '0;
                        c_d.lba  = c_q.lba + 48'd1;
                        c_d.left = c_q.left - 17'd1;
                        if (c_q.left == 17'd1) begin
                            c_d.st  = ST_IDLE;
                            c_d.irq = 1'b1;
                        end
                    end else begin
                        c_d.widx = c_q.widx + 1'b1;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign bsy      = (c_q.st == ST_BUSY) || (c_q.st == ST_DMA);
    assign drq      = (c_q.st == ST_PIO);
    assign dma_req  = (c_q.st == ST_DMA);
    assign err      = c_q.err;
    assign irq      = c_q.irq;
    assign lba      = c_q.lba;
    assign word_idx = c_q.widx;

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_tf_pkg::*;
#(
    parameter int BUSY_CYCLES      = 4,
    parameter int IDENTIFY_WORDS   = 256,
    parameter int WORDS_PER_SECTOR = 256,
    parameter bit SLAVE_PRESENT    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_cs,
    input  logic        ctl_cs,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        intrq,
    output logic        dma_req,
    input  logic        dma_ack,
    output logic [47:0] cur_lba
);

    localparam int MAXW   = (IDENTIFY_WORDS > WORDS_PER_SECTOR) ? IDENTIFY_WORDS : WORDS_PER_SECTOR;
    localparam int WIDX_W = (MAXW > 2) ? $clog2(MAXW) : 1;

    logic [HIST_REGS-1:0][7:0] last_bytes;
    logic [7:0]                sel_byte;
    logic [47:0]               lba_value;
    logic [16:0]               sect_value;
    logic                      sel_present;
    logic                      cmd_wr, data_rd, stat_rd;
    logic                      bsy, drq, err;
    logic [WIDX_W-1:0]         word_idx;
    logic [15:0]               ident_word;
    logic [7:0]                status_byte;
    logic [1:0]                hist_idx;

    assign sel_present = SLAVE_PRESENT || !sel_byte[SEL_DEV_BIT];
    assign cmd_wr  = cmd_cs && reg_wr && (reg_addr == OFS_CMDSTAT) && sel_present;
    assign data_rd = cmd_cs && reg_rd && (reg_addr == OFS_DATA) && sel_present;
    assign stat_rd = cmd_cs && reg_rd && (reg_addr == OFS_CMDSTAT) && sel_present;

    ata_tf_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cmd_cs && reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata[7:0]),
        .last_bytes (last_bytes),
        .sel_byte   (sel_byte),
        .lba_value  (lba_value),
        .sect_value (sect_value)
    );

    ata_tf_ctrl #(
        .BUSY_CYCLES      (BUSY_CYCLES),
        .IDENTIFY_WORDS   (IDENTIFY_WORDS),
        .WORDS_PER_SECTOR (WORDS_PER_SECTOR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_code  (reg_wdata[7:0]),
        .data_rd   (data_rd),
        .stat_rd   (stat_rd),
        .dma_ack   (dma_ack),
        .start_lba (lba_value),
        .sectors   (sect_value),
        .bsy       (bsy),
        .drq       (drq),
        .err       (err),
        .irq       (intrq),
        .dma_req   (dma_req),
        .lba       (cur_lba),
        .word_idx  (word_idx)
    );

    ata_tf_ident #(.IDX_W(WIDX_W)) u_ident (
        .idx  (word_idx),
        .word (ident_word)
    );

    assign status_byte = sel_present ? {bsy, ~bsy, 2'b00, drq, 2'b00, err} : 8'h00;
    assign hist_idx    = 2'(reg_addr - OFS_COUNT);

    always_comb begin
        reg_rdata = '0;
        if (cmd_cs && reg_rd) begin
            unique case (reg_addr)
                OFS_DATA:    reg_rdata = (drq && sel_present) ? ident_word : 16'h0000;
                OFS_ERR:     reg_rdata = {13'd0, err, 2'b00};
                OFS_SELECT:  reg_rdata = {8'd0, sel_byte};
                OFS_CMDSTAT: reg_rdata = {8'd0, status_byte};
                default:     reg_rdata = {8'd0, last_bytes[hist_idx]};
            endcase
        end else if (ctl_cs && reg_rd && reg_addr == OFS_ALTSTAT) begin
            reg_rdata = {8'd0, status_byte};
        end
    end

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_cs,
    input logic        ctl_cs,
    input logic [2:0]  reg_addr,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [15:0] reg_rdata,
    input logic        intrq,
    input logic        dma_req,
    input logic        dma_ack,
    input logic [47:0] cur_lba
);

    logic alt_rd;
    assign alt_rd = ctl_cs && !cmd_cs && reg_rd && reg_addr == 3'd2;

    // R6
    dma_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> intrq);

    // R6
    lba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> $stable(cur_lba));

    // R9
    alt_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intrq && alt_rd) |=> intrq);

    // R4
    bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_rd |-> !(reg_rdata[7] && reg_rdata[3]));

    // R8
    err_no_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_rd && reg_rdata[0]) |-> !reg_rdata[7]);

    // R6
    dma_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_rd && dma_req && reg_rdata != 16'h0000) |-> reg_rdata[7]);

    // R6
    ack_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |-> dma_req);

endmodule

bind ata_taskfile ata_taskfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_cs    (cmd_cs),
    .ctl_cs    (ctl_cs),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .intrq     (intrq),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .cur_lba   (cur_lba)
);

// File: tb/ata_taskfile_bench.sv
`timescale 1ns/1ps
module ata_taskfile_bench;

    localparam int BUSY = 3;
    localparam int IW   = 256;
    localparam int WPS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_cs = 1'b0, ctl_cs = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        intrq, dma_req;
    logic        dma_ack = 1'b0;
    logic [47:0] cur_lba;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ata_taskfile #(
        .BUSY_CYCLES      (BUSY),
        .IDENTIFY_WORDS   (IW),
        .WORDS_PER_SECTOR (WPS),
        .SLAVE_PRESENT    (1'b0)
    ) u_ata_taskfile (
        .clk(clk), .rst_n(rst_n), .cmd_cs(cmd_cs), .ctl_cs(ctl_cs),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intrq(intrq),
        .dma_req(dma_req), .dma_ack(dma_ack), .cur_lba(cur_lba)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_last [2:5];
    logic [7:0]  m_prev [2:5];
    logic [7:0]  m_sel;
    int          m_busy, m_pio, m_dma, m_done, m_sects;
    bit          m_job_dma, m_err, m_irq;
    logic [47:0] m_lba;

    function automatic bit m_present();
        return !m_sel[4];
    endfunction

    function automatic logic [15:0] m_status();
        bit b;
        if (!m_present()) return 16'h0000;
        b = (m_busy > 0) || (m_dma > 0);
        return {8'h00, b, !b, 2'b00, (m_pio > 0), 2'b00, m_err};
    endfunction

    function automatic logic [15:0] ident_exp(int k);
        logic [7:0] kb;
        if (k == 49) return 16'h0100;
        if (k == 83) return 16'h0400;
        kb = 8'(k);
        return {kb, ~kb};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 2; i <= 5; i++) begin m_last[i] = 8'h00; m_prev[i] = 8'h00; end
            m_sel = 8'h00; m_busy = 0; m_pio = 0; m_dma = 0; m_done = 0; m_sects = 0;
            m_job_dma = 0; m_err = 0; m_irq = 0; m_lba = '0;
        end else begin
            bit pres;
            bit idle;
            pres = m_present();
            idle = (m_busy == 0) && (m_pio == 0) && (m_dma == 0);
            if (cmd_cs && reg_rd && reg_addr == 3'd7 && pres) m_irq = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    if (m_job_dma) begin m_dma = m_sects * WPS; m_done = 0; end
                    else begin m_pio = IW; m_irq = 1; end
                end
            end else if (m_pio > 0) begin
                if (cmd_cs && reg_rd && reg_addr == 3'd0 && pres) m_pio--;
            end else if (m_dma > 0) begin
                if (dma_ack) begin
                    m_dma--; m_done++;
                    if (m_done % WPS == 0) m_lba = m_lba + 48'd1;
                    if (m_dma == 0) m_irq = 1;
                end
            end
            if (cmd_cs && reg_wr) begin
                if (reg_addr >= 3'd2 && reg_addr <= 3'd5) begin
                    m_prev[reg_addr] = m_last[reg_addr];
                    m_last[reg_addr] = reg_wdata[7:0];
                end else if (reg_addr == 3'd6) begin
                    m_sel = reg_wdata[7:0];
                end else if (reg_addr == 3'd7 && pres && idle) begin
                    if (reg_wdata[7:0] == 8'hEC) begin
                        m_busy = BUSY; m_job_dma = 0; m_err = 0;
                    end else if (reg_wdata[7:0] == 8'h25) begin
                        m_busy = BUSY; m_job_dma = 1; m_err = 0;
                        m_sects = ({m_prev[2], m_last[2]} == 16'd0) ? 65536
                                : int'({m_prev[2], m_last[2]});
                        m_lba = {m_prev[5], m_prev[4], m_prev[3], m_last[5], m_last[4], m_last[3]};
                    end else begin
                        m_err = 1; m_irq = 1;
                    end
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // every cycle: outputs against model (R1 R6 R9 R10 R11)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R6 dma_req", 48'(dma_req), 48'(m_dma > 0));
            check("R9 intrq", 48'(intrq), 48'(m_irq));
            check("R2 cur_lba", cur_lba, m_lba);
        end
    end

    // bus tasks: called at a falling edge, return at the next one
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cmd_cs = 1; reg_wr = 1; reg_addr = a; reg_wdata = {8'h00, d};
        @(negedge clk);
        cmd_cs = 0; reg_wr = 0;
    endtask

    task automatic rd_chk(input string req, input bit ctl, input logic [2:0] a,
                          input logic [15:0] exp);
        cmd_cs = !ctl; ctl_cs = ctl; reg_rd = 1; reg_addr = a;
        #1;
        check(req, 48'(reg_rdata), 48'(exp));
        @(negedge clk);
        cmd_cs = 0; ctl_cs = 0; reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dma_words(input int n, input bit gaps);
        int got = 0;
        bit ph = 0;
        while (got < n) begin
            dma_ack = dma_req && !ph;
            if (dma_ack) got++;
            if (gaps) ph = !ph;
            @(negedge clk);
        end
        dma_ack = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        rd_chk("R1 status", 0, 3'd7, 16'h0040);
        check("R1 intrq", 48'(intrq), 48'd0);
        check("R1 dma_req", 48'(dma_req), 48'd0);
        check("R1 cur_lba", cur_lba, 48'd0);

        // R3 readback of history registers and select
        wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56); wr(3'd5, 8'h78); wr(3'd6, 8'hE0);
        rd_chk("R3 off2", 0, 3'd2, 16'h0012);
        rd_chk("R3 off3", 0, 3'd3, 16'h0034);
        rd_chk("R3 off4", 0, 3'd4, 16'h0056);
        rd_chk("R3 off5", 0, 3'd5, 16'h0078);
        rd_chk("R3 off6", 0, 3'd6, 16'h00E0);

        // R8 unknown command, R9 alt status keeps irq
        wr(3'd7, 8'h5A);
        rd_chk("R8 alt err", 1, 3'd2, 16'h0041);
        check("R9 irq after alt", 48'(intrq), 48'd1);
        rd_chk("R8 errreg", 0, 3'd1, 16'h0004);
        rd_chk("R9 status clears", 0, 3'd7, 16'h0041);
        check("R9 irq cleared", 48'(intrq), 48'd0);

        // R10 absent slave
        wr(3'd6, 8'hF0);
        rd_chk("R10 status absent", 0, 3'd7, 16'h0000);
        rd_chk("R10 alt absent", 1, 3'd2, 16'h0000);
        wr(3'd7, 8'hEC);
        idle(BUSY + 2);
        wr(3'd6, 8'hE0);
        rd_chk("R10 cmd ignored", 0, 3'd7, 16'h0041);
        check("R10 no irq", 48'(intrq), 48'd0);

        // R4/R5 identify
        wr(3'd7, 8'hEC);
        rd_chk("R4 busy", 1, 3'd2, 16'h0080);
        idle(BUSY - 2);
        rd_chk("R4 busy last", 1, 3'd2, 16'h0080);
        rd_chk("R5 drq", 1, 3'd2, 16'h0048);
        check("R5 irq", 48'(intrq), 48'd1);
        wr(3'd7, 8'h25);                       // R11 ignored during data phase
        rd_chk("R11 still drq", 0, 3'd7, 16'h0048);
        for (int k = 0; k < IW; k++) begin
            rd_chk("R5 word", 0, 3'd0, ident_exp(k));
        end
        rd_chk("R5 done", 0, 3'd7, 16'h0040);

        // R2/R6 48-bit DMA, two sectors, hi bytes then lo bytes
        wr(3'd2, 8'h00); wr(3'd3, 8'h44); wr(3'd4, 8'h55); wr(3'd5, 8'h66);
        wr(3'd2, 8'h02); wr(3'd3, 8'h11); wr(3'd4, 8'h22); wr(3'd5, 8'h33);
        wr(3'd7, 8'h25);
        check("R2 lba", cur_lba, 48'h6655_4433_2211);
        idle(BUSY);
        check("R6 req up", 48'(dma_req), 48'd1);
        rd_chk("R6 dma status", 1, 3'd2, 16'h0080);
        dma_words(3, 1);
        wr(3'd7, 8'hEC);                       // R11 ignored during DMA
        dma_words(5, 1);
        idle(1);
        check("R6 req down", 48'(dma_req), 48'd0);
        check("R6 lba end", cur_lba, 48'h6655_4433_2213);
        rd_chk("R6 done status", 0, 3'd7, 16'h0040);

        // R7 count 0 = 65536 sectors, carry across byte boundary
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd2, 8'h00); wr(3'd3, 8'hF0); wr(3'd4, 8'hFF); wr(3'd5, 8'h00);
        wr(3'd7, 8'h25);
        idle(BUSY);
        dma_words(300 * WPS, 0);
        check("R7 still req", 48'(dma_req), 48'd1);
        check("R7 lba", cur_lba, 48'h0000_0001_011C);

        finished = 1;
        rst_n = 0;
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule